// File: doc/BRIEF.md
# Entropy Bit-Stream Health Monitor

This block sits beside a raw noise source and checks the serial bit stream online, one bit for each cycle in which `bit_valid` is high. It runs four independent tests in parallel. A windowed ones-count test checks for bias. Two run-length tests use different thresholds: a shorter identical-bit run counts as a statistical test fault, and a longer one counts as a noise-source fault. A word-repeat test assembles the stream into words and flags two equal words in a row.

Each test sets a sticky flag in an 8-bit fault vector. The flag positions match the status layout that the surrounding logic decodes. A matching per-bit clear input drops a flag. Testing never pauses: a test whose condition is still present sets its flag again on the next valid bit. Clearing the monobit flag also restarts the ones-count window, so software can resynchronise the window with the stream.

Top module: `entropy_health_mon`

## Requirements
- R1: The fault vector uses bit 7 for monobit, bit 5 for long run, bit 3 for noise run and bit 2 for repeated word. All other bits read 0. Reset clears every flag.
- R2: Only cycles with `bit_valid` high advance any test. `bit_in` is ignored in other cycles, and no flag can become set in such a cycle.
- R3: Every `WINDOW_BITS` valid bits, the count of ones in that window is compared with `ONES_LO` and `ONES_HI`, default 20000, 9655 and 10345. Both bounds pass. A count outside them sets bit 7 in the cycle after the window's last bit is taken, and not before.
- R4: The run length restarts at 1 whenever a bit differs from the previous valid bit and saturates at `NOISE_RUN`. Bit 5 sets when the run reaches `LONG_RUN`, default 34. A run of 33 sets nothing.
- R5: Bit 3 sets when the run reaches `NOISE_RUN`, default 48. A run of 47 does not set it. Bit 3 never newly sets without bit 5.
- R6: Valid bits are shifted MSB-first into `WORD_W`-bit words, default 32. Bit 2 sets when a completed word equals the previously completed one. The first word after reset and a partly filled word never set it.
- R7: A flag stays set until its `clr_i` bit is pulsed. The clear takes effect one cycle later and touches no other flag. A new detection in the same cycle as the clear wins over the clear.
- R8: Testing continues while flags are set. After a clear, a run still at or above a threshold sets its flag again on the next valid bit.
- R9: `clr_i[7]` restarts the ones-count window and drops any bit that arrives in the same cycle. No clear bit resets the run counter or the word assembler.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bit_valid | input | 1 | Marks `bit_in` as a fresh noise bit |
| bit_in | input | 1 | Raw noise bit |
| clr_i | input | 8 | Per-flag clear pulses, same layout as `fault_o` |
| fault_o | output | 8 | Sticky fault flags |

## Verification
A wrong run counter shows up as a long or noise flag that sets one bit early or late around the 34 and 48 boundaries, so the bench drives runs exactly one short of and at each threshold. A bad window counter or ones counter shows nothing until the window closes, 20000 valid bits later. For that reason the bench checks the monobit flag at the bits just before and at the close of the window, on both sides of each bound and after a window restart. A broken word assembler shows as a missing or spurious repeat flag on the 64th bit of a periodic or distinct-word stream.

// File: rtl/ehm_pkg.sv
package ehm_pkg;
   localparam int FLT_W     = 8;
   localparam int FLT_MONO  = 7;
   localparam int FLT_LONG  = 5;
   localparam int FLT_NOISE = 3;
   localparam int FLT_STUCK = 2;
   localparam logic [FLT_W-1:0] FLT_MASK =
      FLT_W'((1 << FLT_MONO) | (1 << FLT_LONG) | (1 << FLT_NOISE) | (1 << FLT_STUCK));
endpackage

// File: rtl/ehm_monobit.sv
module ehm_monobit #(
   parameter int WINDOW_BITS = 20000,
   parameter int ONES_LO     = 9655,
   parameter int ONES_HI     = 10345,
   localparam int CW         = $clog2(WINDOW_BITS + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          restart,
   input  logic          bit_valid,
   input  logic          bit_in,
   output logic          hit,
   output logic [CW-1:0] win_pos
);
   localparam logic [CW-1:0] LAST_C = CW'(WINDOW_BITS - 1);
   localparam logic [CW-1:0] LO_C   = CW'(ONES_LO);
   localparam logic [CW-1:0] HI_C   = CW'(ONES_HI);

   logic [CW-1:0] pos_q, ones_q, total;
   logic          last;

   always_comb begin
      total = ones_q + CW'(bit_in);
      last  = (pos_q == LAST_C);
      hit   = bit_valid & ~restart & last & ((total < LO_C) | (total > HI_C));
   end

   always_ff @(posedge clk) begin
      if (!rst_n || restart) begin
         pos_q  <= '0;
         ones_q <= '0;
      end else if (bit_valid) begin
         if (last) begin
            pos_q  <= '0;
            ones_q <= '0;
         end else begin
            pos_q  <= pos_q + 1'b1;
            ones_q <= total;
         end
      end
   end

   assign win_pos = pos_q;
endmodule

// File: rtl/ehm_runlen.sv
module ehm_runlen #(
   parameter int LONG_RUN  = 34,
   parameter int NOISE_RUN = 48,
   localparam int RW       = $clog2(NOISE_RUN + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          bit_valid,
   input  logic          bit_in,
   output logic          long_hit,
   output logic          noise_hit,
   output logic [RW-1:0] run_len
);
   localparam logic [RW-1:0] LONG_C  = RW'(LONG_RUN);
   localparam logic [RW-1:0] NOISE_C = RW'(NOISE_RUN);

   logic          prev_q, have_q;
   logic [RW-1:0] run_q, run_nxt;

   always_comb begin
      if (!have_q || (bit_in != prev_q)) run_nxt = RW'(1);
      else if (run_q == NOISE_C)         run_nxt = NOISE_C;
      else                               run_nxt = run_q + 1'b1;
      long_hit  = bit_valid & (run_nxt >= LONG_C);
      noise_hit = bit_valid & (run_nxt >= NOISE_C);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         prev_q <= 1'b0;
         have_q <= 1'b0;
         run_q  <= '0;
      end else if (bit_valid) begin
         prev_q <= bit_in;
         have_q <= 1'b1;
         run_q  <= run_nxt;
      end
   end

   assign run_len = run_q;
endmodule

// File: rtl/ehm_stuckword.sv
module ehm_stuckword #(
   parameter int WORD_W = 32,
   localparam int BW    = $clog2(WORD_W)
) (
   input  logic clk,
   input  logic rst_n,
   input  logic bit_valid,
   input  logic bit_in,
   output logic hit
);
   localparam logic [BW-1:0] LAST_C = BW'(WORD_W - 1);

   logic [WORD_W-1:0] shreg_q, prev_q, word_full;
   logic [BW-1:0]     cnt_q;
   logic              have_q, done;

   always_comb begin
      word_full = {shreg_q[WORD_W-2:0], bit_in};
      done      = bit_valid & (cnt_q == LAST_C);
      hit       = done & have_q & (word_full == prev_q);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         shreg_q <= '0;
         prev_q  <= '0;
         cnt_q   <= '0;
         have_q  <= 1'b0;
      end else if (bit_valid) begin
         shreg_q <= word_full;
         cnt_q   <= done ? '0 : cnt_q + 1'b1;
         if (done) begin
            prev_q <= word_full;
            have_q <= 1'b1;
         end
      end
   end
endmodule

// File: rtl/entropy_health_mon.sv
module entropy_health_mon
   import ehm_pkg::*;
#(
   parameter int WINDOW_BITS = 20000,
   parameter int ONES_LO     = 9655,
   parameter int ONES_HI     = 10345,
   parameter int LONG_RUN    = 34,
   parameter int NOISE_RUN   = 48,
   parameter int WORD_W      = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             bit_valid,
   input  logic             bit_in,
   input  logic [FLT_W-1:0] clr_i,
   output logic [FLT_W-1:0] fault_o
);
   localparam int CW = $clog2(WINDOW_BITS + 1);
   localparam int RW = $clog2(NOISE_RUN + 1);

   if (WINDOW_BITS < 2)          begin : g_bad_win   $error("WINDOW_BITS too small"); end
   if (ONES_LO > ONES_HI)        begin : g_bad_bnd   $error("ONES_LO above ONES_HI"); end
   if (ONES_HI > WINDOW_BITS)    begin : g_bad_hi    $error("ONES_HI above window"); end
   if (LONG_RUN < 2)             begin : g_bad_long  $error("LONG_RUN too small"); end
   if (NOISE_RUN < LONG_RUN)     begin : g_bad_noise $error("NOISE_RUN below LONG_RUN"); end
   if (WORD_W < 2)               begin : g_bad_word  $error("WORD_W too small"); end

   logic          mono_hit, long_hit, noise_hit, stuck_hit;
   logic [CW-1:0] win_pos_w;
   logic [RW-1:0] run_len_w;
   logic [3:0]    hits;
   logic          unused_clr;

   ehm_monobit #(.WINDOW_BITS(WINDOW_BITS), .ONES_LO(ONES_LO), .ONES_HI(ONES_HI)) u_mono (
      .clk(clk), .rst_n(rst_n), .restart(clr_i[FLT_MONO]),
      .bit_valid(bit_valid), .bit_in(bit_in), .hit(mono_hit), .win_pos(win_pos_w));

   ehm_runlen #(.LONG_RUN(LONG_RUN), .NOISE_RUN(NOISE_RUN)) u_run (
      .clk(clk), .rst_n(rst_n), .bit_valid(bit_valid), .bit_in(bit_in),
      .long_hit(long_hit), .noise_hit(noise_hit), .run_len(run_len_w));

   ehm_stuckword #(.WORD_W(WORD_W)) u_word (
      .clk(clk), .rst_n(rst_n), .bit_valid(bit_valid), .bit_in(bit_in), .hit(stuck_hit));

   assign hits       = {mono_hit, long_hit, noise_hit, stuck_hit};
   assign unused_clr = ^(clr_i & ~FLT_MASK);

   for (genvar i = 0; i < FLT_W; i++) begin : g_flt
      localparam int IDX = (i == FLT_MONO)  ? 3 :
                           (i == FLT_LONG)  ? 2 :
                           (i == FLT_NOISE) ? 1 :
                           (i == FLT_STUCK) ? 0 : -1;
      if (IDX >= 0) begin : g_sticky
         logic q;
         always_ff @(posedge clk) begin
            if (!rst_n) q <= 1'b0;
            else        q <= (q & ~clr_i[i]) | hits[IDX];
         end
         assign fault_o[i] = q;
      end else begin : g_zero
         assign fault_o[i] = 1'b0;
      end
   end
endmodule

// File: rtl/ehm_checker.sv
module ehm_checker
   import ehm_pkg::*;
#(
   parameter int WINDOW_BITS = 20000,
   parameter int NOISE_RUN   = 48,
   localparam int CW         = $clog2(WINDOW_BITS + 1),
   localparam int RW         = $clog2(NOISE_RUN + 1)
) (
   input logic             clk,
   input logic             rst_n,
   input logic             bit_valid,
   input logic [FLT_W-1:0] clr_i,
   input logic [FLT_W-1:0] fault_o,
   input logic [RW-1:0]    run_len,
   input logic [CW-1:0]    win_pos
);
   localparam logic [RW-1:0] NOISE_C = RW'(NOISE_RUN);
   localparam logic [CW-1:0] WIN_C   = CW'(WINDOW_BITS);

   // R7: a set flag only drops when its clear bit was pulsed
   assert_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (((($past(fault_o) & ~$past(clr_i)) & ~fault_o)) == '0));

   // R2: an idle cycle cannot raise any flag
   assert_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !bit_valid |=> ((fault_o & ~$past(fault_o)) == '0));

   // R5: a newly raised noise flag comes with the long-run flag
   assert_noise_long_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(fault_o[FLT_NOISE]) |-> fault_o[FLT_LONG]);

   // R4: run length saturates at the noise threshold
   assert_run_sat_R4: assert property (@(posedge clk) disable iff (!rst_n)
      run_len <= NOISE_C);

   // R3: window position stays inside the window
   assert_window_R3: assert property (@(posedge clk) disable iff (!rst_n)
      win_pos < WIN_C);
endmodule

bind entropy_health_mon ehm_checker #(.WINDOW_BITS(WINDOW_BITS), .NOISE_RUN(NOISE_RUN)) u_chk (
   .clk(clk), .rst_n(rst_n), .bit_valid(bit_valid), .clr_i(clr_i),
   .fault_o(fault_o), .run_len(run_len_w), .win_pos(win_pos_w));

// File: tb/tb_entropy_health_mon.sv
module tb_entropy_health_mon;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       bit_valid = 1'b0;
   logic       bit_in = 1'b0;
   logic [7:0] clr_i = 8'h00;
   logic [7:0] fault_o;
   int         n_checks = 0;
   int         n_fail = 0;

   always #4 clk = ~clk;

   entropy_health_mon dut (
      .clk(clk), .rst_n(rst_n), .bit_valid(bit_valid), .bit_in(bit_in),
      .clr_i(clr_i), .fault_o(fault_o));

   // {mode, bit count, expected flags}; mode 0 distinct balanced words, 1 zeros, 2 ones, 3 alternating from 0
   localparam int NV = 10;
   localparam logic [27:0] VEC [NV] = '{
      {4'd0, 16'd200,   8'h00},  // R6 distinct words, R4 short runs
      {4'd1, 16'd33,    8'h00},  // R4 one below long threshold
      {4'd1, 16'd34,    8'h20},  // R4 at long threshold
      {4'd2, 16'd47,    8'h20},  // R5 one below noise threshold
      {4'd2, 16'd48,    8'h28},  // R5 at noise threshold
      {4'd2, 16'd64,    8'h2C},  // R6 two equal words
      {4'd3, 16'd64,    8'h04},  // R6 repeated 0x55555555
      {4'd3, 16'd63,    8'h00},  // R6 second word incomplete
      {4'd0, 16'd20000, 8'h00},  // R3 exactly 10000 ones
      {4'd1, 16'd20000, 8'hAC}   // R3 zero ones plus runs and words
   };

   function automatic logic bal_bit(int n);
      logic [15:0] k;
      logic [31:0] w;
      k = 16'(n / 32);
      w = {k, ~k};
      return w[31 - (n % 32)];
   endfunction

   task automatic chk(input string req, input logic [7:0] mask, input logic [7:0] exp);
      n_checks++;
      if ((fault_o & mask) !== exp) begin
         n_fail++;
         $display("FAIL %s: fault=%h expected %h", req, fault_o & mask, exp);
      end
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0; bit_valid = 1'b0; clr_i = 8'h00;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
   endtask

   task automatic send(input logic b);
      @(negedge clk);
      bit_valid = 1'b1; bit_in = b; clr_i = 8'h00;
   endtask

   task automatic send_clr(input logic b, input logic [7:0] m);
      @(negedge clk);
      bit_valid = 1'b1; bit_in = b; clr_i = m;
   endtask

   task automatic idle();
      @(negedge clk);
      bit_valid = 1'b0; clr_i = 8'h00;
   endtask

   task automatic pulse_clr(input logic [7:0] m);
      @(negedge clk);
      bit_valid = 1'b0; clr_i = m;
      @(negedge clk);
      clr_i = 8'h00;
   endtask

   task automatic drive_seg(input int mode, input int cnt);
      for (int n = 0; n < cnt; n++) begin
         case (mode)
            0:       send(bal_bit(n));
            1:       send(1'b0);
            2:       send(1'b1);
            default: send(n[0]);
         endcase
      end
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog: run did not finish, actual hung expected done");
      $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
   end

   initial begin
      // R1 reset state
      do_reset();
      idle();
      chk("R1 reset state", 8'hFF, 8'h00);

      // table walk
      for (int e = 0; e < NV; e++) begin
         do_reset();
         drive_seg(int'(VEC[e][27:24]), int'(VEC[e][23:8]));
         idle();
         chk($sformatf("R1/R3/R4/R5/R6 table entry %0d", e), 8'hFF, VEC[e][7:0]);
      end

      // R2: idle cycles with bit_in=1 do not break a zero run
      do_reset();
      drive_seg(1, 20);
      for (int n = 0; n < 10; n++) begin
         @(negedge clk); bit_valid = 1'b0; bit_in = 1'b1;
      end
      chk("R2 idle bits ignored", 8'hFF, 8'h00);
      drive_seg(1, 14);
      idle();
      chk("R2 run spans idle gap", 8'hFF, 8'h20);

      // R7 / R8: sticky, individual clear, reassert, set wins over clear
      do_reset();
      drive_seg(2, 64);
      idle();
      chk("R7 flags before clear", 8'hFF, 8'h2C);
      pulse_clr(8'h20);
      chk("R7 clear long only", 8'hFF, 8'h0C);
      pulse_clr(8'h08);
      chk("R7 clear noise only", 8'hFF, 8'h04);
      send(1'b1);
      idle();
      chk("R8 saturated run reasserts", 8'hFF, 8'h2C);
      send_clr(1'b1, 8'h28);
      idle();
      chk("R7 detection wins over clear", 8'hFF, 8'h2C);
      pulse_clr(8'hFF);
      chk("R7 clear all", 8'hFF, 8'h00);
      send(1'b0);
      idle();
      chk("R4 run restarts on change", 8'hFF, 8'h00);
      drive_seg(2, 5);
      do_reset();
      idle();
      chk("R1 reset drops sticky flags", 8'hFF, 8'h00);

      // R9: clear does not reset run counter
      do_reset();
      drive_seg(1, 30);
      pulse_clr(8'hFF);
      drive_seg(1, 4);
      idle();
      chk("R9 run survives clear", 8'hFF, 8'h20);

      // R9: clear does not reset word assembler
      do_reset();
      drive_seg(3, 32);
      pulse_clr(8'hFF);
      drive_seg(3, 32);
      idle();
      chk("R9 word history survives clear", 8'h04, 8'h04);

      // R9 / R3: window restart on monobit clear, low bound minus one
      do_reset();
      drive_seg(2, 100);
      pulse_clr(8'h80);
      chk("R9 monobit clear leaves others", 8'hFF, 8'h2C);
      drive_seg(2, 9654);
      drive_seg(1, 10345);
      idle();
      chk("R3 no verdict before window end", 8'h80, 8'h00);
      send(1'b0);
      idle();
      chk("R9/R3 restarted window below low bound", 8'h80, 8'h80);

      // R3 bounds inclusive and above high bound
      do_reset();
      drive_seg(2, 9655);
      drive_seg(1, 10345);
      idle();
      chk("R3 count at low bound passes", 8'h80, 8'h00);

      do_reset();
      drive_seg(2, 10346);
      drive_seg(1, 9654);
      idle();
      chk("R3 count above high bound", 8'h80, 8'h80);

      do_reset();
      drive_seg(2, 10345);
      drive_seg(1, 9655);
      idle();
      chk("R3 count at high bound passes", 8'h80, 8'h00);

      $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
   end
endmodule